// File: doc/BRIEF.md
# Task Switch Segment Selector Validator

During a hardware task switch, each segment register is reloaded from the incoming task state. This block takes one of those selectors, along with the two descriptor words already fetched for it, and decides whether the load is legal. If it is legal, the block issues a load strobe carrying the assembled base, the expanded limit and the raw flags word. If it is not, the block issues a fault strobe carrying a vector and an error code.

The caller names the destination register class on each request: data (DS, ES, FS or GS), code (CS) or stack (SS). The caller also supplies the current privilege level and a flag that marks a failed descriptor fetch. The descriptor fetch itself is done elsewhere. The result appears one clock after the request.

Top module: `taskseg_load_check`

## Requirements
- R1: One cycle after `req_valid` is high on a clock edge, at most one of `ld_valid` and `flt_valid` is high, for exactly one cycle. Neither strobe is ever high in a cycle that does not follow a request, and both are low after reset.
- R2: A selector is null when bits 15:2 are all zero. A null selector for the data class (`req_dest`=0) produces no strobe at all. A null selector for code (`req_dest`=1) or stack (`req_dest`=2) faults with vector 10.
- R3: For a non-null selector, a set `fetch_err`, or a clear S bit (`desc_hi` bit 12), faults with vector 10.
- R4: For the code class, the descriptor must be code (`desc_hi` bit 11 set) and its DPL (`desc_hi` bits 14:13) must equal the RPL (selector bits 1:0). A conforming descriptor (bit 10) with DPL greater than RPL also faults. Each of these faults uses vector 10.
- R5: For the stack class, the descriptor must be writable data: bit 11 clear and bit 9 set. Its DPL must equal both `req_cpl` and the RPL. Otherwise it faults with vector 10.
- R6: For the data class, code without the readable bit (bit 9) faults with vector 10. When the 4-bit type (`desc_hi` bits 11:8) is below 12, a DPL below the CPL or below the RPL also faults with vector 10. Conforming code skips the privilege test.
- R7: The present bit (`desc_hi` bit 15) is checked only after all of the above. If every earlier check passes and the present bit is clear, the block faults with vector 11. An earlier failure always reports vector 10.
- R8: On a load, `ld_base` = {`desc_hi`[31:24], `desc_hi`[7:0], `desc_lo`[31:16]}, and `ld_flags` equals `desc_hi`.
- R9: On a load, the raw limit is {`desc_hi`[19:16], `desc_lo`[15:0]}, zero-extended. When the granularity bit (`desc_hi` bit 23) is set, `ld_limit` is the raw limit shifted left by 12 with bits 11:0 all ones.
- R10: Every fault's `flt_code` is the selector with bits 1:0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 2 | Destination class: 0 data, 1 code, 2 stack |
| req_sel | input | 16 | Selector being loaded |
| req_cpl | input | 2 | Current privilege level |
| desc_lo | input | 32 | Descriptor low word |
| desc_hi | input | 32 | Descriptor high word |
| fetch_err | input | 1 | Descriptor fetch failed |
| ld_valid | output | 1 | Segment cache load strobe |
| ld_base | output | 32 | Assembled base |
| ld_limit | output | 32 | Expanded limit |
| ld_flags | output | 32 | Descriptor high word passed through |
| flt_valid | output | 1 | Fault strobe |
| flt_vec | output | 8 | Fault vector: 10 invalid task state, 11 not present |
| flt_code | output | 16 | Fault error code |

## Verification
The bench targets the places where the destination class changes the outcome.

- A null selector has a low RPL that must be ignored. It must be silent for a data register, yet must fault for CS and SS. A design that treats all nulls alike would either fault on data registers or load CS.
- The ordering of the present check is tested with a descriptor that is both absent and privilege-violating. A design that tests the present bit first would report vector 11 instead of 10.
- For data registers, conforming code with a low DPL must load, and execute-only code must fault. This catches a comparison of the type field against the wrong threshold.
- The granularity expansion is tested so that dropped low ones are caught.
- The base assembly uses distinct byte values so that swapped byte lanes are caught.

// File: rtl/tsl_pkg.sv
// Shared definitions for the task switch segment validator.
// Assumes the descriptor layout of two 32-bit words, high word holding type and flags.
package tsl_pkg;
    parameter int SEL_W  = 16;
    parameter int WORD_W = 32;
    parameter int VEC_W  = 8;
    parameter logic [VEC_W-1:0] VEC_BAD_TSS = 8'd10;
    parameter logic [VEC_W-1:0] VEC_NOT_PRESENT = 8'd11;

    // Destination register class
    typedef enum logic [1:0] {
        DEST_DATA  = 2'd0,
        DEST_CODE  = 2'd1,
        DEST_STACK = 2'd2
    } dest_e;

    // Bit positions within the descriptor high word
    localparam int HB_RW    = 9;
    localparam int HB_CONF  = 10;
    localparam int HB_CODE  = 11;
    localparam int HB_SYS   = 12;
    localparam int HB_DPL_L = 13;
    localparam int HB_PRES  = 15;
    localparam int HB_GRAN  = 23;

    // Classification outcome of the rule checker
    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_LOAD  = 2'd1,
        OUT_FAULT = 2'd2
    } outcome_e;
endpackage

// File: rtl/tsl_fields.sv
// Extracts the base and the granularity-expanded limit from a descriptor pair.
// Purely combinational; assumes the 32-bit descriptor layout in tsl_pkg.
module tsl_fields
    import tsl_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] lo_word,
    input  logic [W-1:0] hi_word,
    output logic [W-1:0] base,
    output logic [W-1:0] limit
);
    localparam int PAGE_SH = 12;

    logic [19:0] raw_limit;

    // Gather the scattered base bytes
    always_comb begin
        base = {hi_word[31:24], hi_word[7:0], lo_word[31:16]};
    end

    // Form the 20-bit limit and expand it for page granularity
    always_comb begin
        raw_limit = {hi_word[19:16], lo_word[15:0]};
        if (hi_word[HB_GRAN])
            limit = {raw_limit, {PAGE_SH{1'b1}}};
        else
            limit = {{(W-20){1'b0}}, raw_limit};
    end
endmodule

// File: rtl/tsl_rules.sv
// Applies the null, type, privilege and presence rules for one selector load.
// Combinational; the earlier rules take priority over the present-bit test.
module tsl_rules
    import tsl_pkg::*;
(
    input  dest_e             dest,
    input  logic [SEL_W-1:0]  sel,
    input  logic [1:0]        cpl,
    input  logic [WORD_W-1:0] hi_word,
    input  logic              fetch_err,
    output outcome_e          outcome,
    output logic [VEC_W-1:0]  vec
);
    logic       is_null;
    logic [1:0] rpl;
    logic [1:0] dpl;
    logic [3:0] dtype;
    logic       is_code;
    logic       rw_bit;
    logic       conf_bit;
    logic       class_bad;

    // Decode the selector and descriptor fields used by the rules
    always_comb begin
        is_null  = (sel[SEL_W-1:2] == '0);
        rpl      = sel[1:0];
        dpl      = hi_word[HB_DPL_L+1:HB_DPL_L];
        dtype    = hi_word[11:8];
        is_code  = hi_word[HB_CODE];
        rw_bit   = hi_word[HB_RW];
        conf_bit = hi_word[HB_CONF];
    end

    // Evaluate the destination-specific type and privilege rules
    always_comb begin
        class_bad = 1'b0;
        unique case (dest)
            DEST_CODE: begin
                if (!is_code) class_bad = 1'b1;
                if (dpl != rpl) class_bad = 1'b1;
                if (conf_bit && (dpl > rpl)) class_bad = 1'b1;
            end
            DEST_STACK: begin
                if (is_code || !rw_bit) class_bad = 1'b1;
                if ((dpl != cpl) || (dpl != rpl)) class_bad = 1'b1;
            end
            default: begin
                if (is_code && !rw_bit) class_bad = 1'b1;
                if ((dtype < 4'd12) && ((dpl < cpl) || (dpl < rpl))) class_bad = 1'b1;
            end
        endcase
    end

    // Pick the outcome in priority order
    always_comb begin
        outcome = OUT_LOAD;
        vec     = VEC_BAD_TSS;
        if (is_null) begin
            outcome = (dest == DEST_DATA) ? OUT_NONE : OUT_FAULT;
        end else if (fetch_err || !hi_word[HB_SYS] || class_bad) begin
            outcome = OUT_FAULT;
        end else if (!hi_word[HB_PRES]) begin
            outcome = OUT_FAULT;
            vec     = VEC_NOT_PRESENT;
        end
    end
endmodule

// File: rtl/taskseg_load_check.sv
// Top of the task switch selector validator: registers the rule outcome one
// cycle after a request. Assumes the descriptor words are valid with req_valid.
module taskseg_load_check
    import tsl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_dest,
    input  logic [15:0]       req_sel,
    input  logic [1:0]        req_cpl,
    input  logic [31:0]       desc_lo,
    input  logic [31:0]       desc_hi,
    input  logic              fetch_err,
    output logic              ld_valid,
    output logic [31:0]       ld_base,
    output logic [31:0]       ld_limit,
    output logic [31:0]       ld_flags,
    output logic              flt_valid,
    output logic [7:0]        flt_vec,
    output logic [15:0]       flt_code
);
    outcome_e          outcome;
    logic [VEC_W-1:0]  vec_c;
    logic [WORD_W-1:0] base_c;
    logic [WORD_W-1:0] limit_c;
    dest_e             dest_c;

    assign dest_c = dest_e'(req_dest);

    tsl_fields #(.W(WORD_W)) u_fields (
        .lo_word (desc_lo),
        .hi_word (desc_hi),
        .base    (base_c),
        .limit   (limit_c)
    );

    tsl_rules u_rules (
        .dest      (dest_c),
        .sel       (req_sel),
        .cpl       (req_cpl),
        .hi_word   (desc_hi),
        .fetch_err (fetch_err),
        .outcome   (outcome),
        .vec       (vec_c)
    );

    // Register the strobes and their payloads one cycle after a request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid  <= 1'b0;
            flt_valid <= 1'b0;
            ld_base   <= '0;
            ld_limit  <= '0;
            ld_flags  <= '0;
            flt_vec   <= '0;
            flt_code  <= '0;
        end else begin
            ld_valid  <= req_valid && (outcome == OUT_LOAD);
            flt_valid <= req_valid && (outcome == OUT_FAULT);
            if (req_valid) begin
                ld_base  <= base_c;
                ld_limit <= limit_c;
                ld_flags <= desc_hi;
                flt_vec  <= vec_c;
                flt_code <= {req_sel[15:2], 2'b00};
            end
        end
    end
endmodule

// File: rtl/tsl_checker.sv
// Temporal checks on the validator's ports; attached to every instance by bind.
module tsl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_dest,
    input logic [15:0] req_sel,
    input logic        fetch_err,
    input logic        ld_valid,
    input logic [31:0] ld_limit,
    input logic [31:0] ld_flags,
    input logic        flt_valid,
    input logic [7:0]  flt_vec,
    input logic [15:0] flt_code
);
    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_valid && flt_valid));

    a_r1_after_request: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid || flt_valid) |-> $past(req_valid));

    a_r2_null_data_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_sel[15:2] == 14'd0 && req_dest == 2'd0) |=> !(ld_valid || flt_valid));

    a_r3_fetch_err_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && fetch_err) |=> !ld_valid);

    a_r7_np_vector_only_on_good_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_vec == 8'd11) |-> !$past(fetch_err));

    a_r9_gran_low_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_flags[23]) |-> (ld_limit[11:0] == 12'hFFF));

    a_r10_code_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> (flt_code[1:0] == 2'b00));
endmodule

bind taskseg_load_check tsl_checker u_tsl_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_dest  (req_dest),
    .req_sel   (req_sel),
    .fetch_err (fetch_err),
    .ld_valid  (ld_valid),
    .ld_limit  (ld_limit),
    .ld_flags  (ld_flags),
    .flt_valid (flt_valid),
    .flt_vec   (flt_vec),
    .flt_code  (flt_code)
);

// File: tb/test_taskseg_load_check.sv
module test_taskseg_load_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_dest = 2'd0;
    logic [15:0] req_sel = 16'd0;
    logic [1:0]  req_cpl = 2'd0;
    logic [31:0] desc_lo = 32'd0;
    logic [31:0] desc_hi = 32'd0;
    logic        fetch_err = 1'b0;
    logic        ld_valid;
    logic [31:0] ld_base;
    logic [31:0] ld_limit;
    logic [31:0] ld_flags;
    logic        flt_valid;
    logic [7:0]  flt_vec;
    logic [15:0] flt_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    taskseg_load_check i_taskseg_load_check (.*);

    // Build a descriptor high word from its fields
    function automatic logic [31:0] hiw(input logic [7:0] bhi, input logic g,
        input logic [3:0] lhi, input logic p, input logic [1:0] dpl,
        input logic s, input logic [3:0] typ, input logic [7:0] bmid);
        return {bhi, g, 3'b000, lhi, p, dpl, s, typ, bmid};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one request; kind 0 none, 1 load, 2 fault
    task automatic run(input string tag, input logic [1:0] dest, input logic [15:0] sel,
        input logic [1:0] cpl, input logic [31:0] lo, input logic [31:0] hi,
        input logic ferr, input int kind, input logic [7:0] vec);
        @(negedge clk);
        req_valid = 1'b1; req_dest = dest; req_sel = sel; req_cpl = cpl;
        desc_lo = lo; desc_hi = hi; fetch_err = ferr;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " ld_valid"}, {31'd0, ld_valid}, {31'd0, kind == 1});
        chk({tag, " flt_valid"}, {31'd0, flt_valid}, {31'd0, kind == 2});
        if (kind == 2) begin
            chk({tag, " flt_vec"}, {24'd0, flt_vec}, {24'd0, vec});
            chk({tag, " R10 flt_code"}, {16'd0, flt_code}, {16'd0, sel & 16'hFFFC});
        end
        @(negedge clk);
        chk({tag, " R1 idle strobes"}, {30'd0, ld_valid, flt_valid}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 reset ld_valid", {31'd0, ld_valid}, 32'd0);
        chk("R1 reset flt_valid", {31'd0, flt_valid}, 32'd0);
    endtask

    task automatic t_null();
        run("R2 null data", 2'd0, 16'h0003, 2'd0, 32'h0, 32'h0, 1'b0, 0, 8'd0);
        run("R2 null code", 2'd1, 16'h0000, 2'd0, 32'h0, 32'h0, 1'b0, 2, 8'd10);
        run("R2 null stack", 2'd2, 16'h0002, 2'd2, 32'h0, 32'h0, 1'b0, 2, 8'd10);
    endtask

    task automatic t_fetch_sys();
        run("R3 fetch err", 2'd0, 16'h0010, 2'd0, 32'h0,
            hiw(8'h0, 1'b0, 4'h0, 1'b1, 2'd0, 1'b1, 4'h2, 8'h0), 1'b1, 2, 8'd10);
        run("R3 system desc", 2'd0, 16'h1237, 2'd0, 32'h0,
            hiw(8'h0, 1'b0, 4'h0, 1'b1, 2'd3, 1'b0, 4'h2, 8'h0), 1'b0, 2, 8'd10);
    endtask

    task automatic t_code();
        run("R4 code ok", 2'd1, 16'h0008, 2'd0, 32'h1234ABCD,
            hiw(8'h56, 1'b0, 4'h7, 1'b1, 2'd0, 1'b1, 4'hA, 8'h9A), 1'b0, 1, 8'd0);
        chk("R8 base", ld_base, 32'h569A1234);
        chk("R9 limit byte gran", ld_limit, 32'h0007ABCD);
        chk("R8 flags", ld_flags, 32'h56079A9A);
        run("R4 code from data", 2'd1, 16'h0008, 2'd0, 32'h0,
            hiw(8'h0, 1'b0, 4'h0, 1'b1, 2'd0, 1'b1, 4'h2, 8'h0), 1'b0, 2, 8'd10);
        run("R4 dpl ne rpl", 2'd1, 16'h0008, 2'd0, 32'h0,
            hiw(8'h0, 1'b0, 4'h0, 1'b1, 2'd1, 1'b1, 4'hA, 8'h0), 1'b0, 2, 8'd10);
        run("R4 conforming dpl gt rpl", 2'd1, 16'h0009, 2'd1, 32'h0,
            hiw(8'h0, 1'b0, 4'h0, 1'b1, 2'd2, 1'b1, 4'hE, 8'h0), 1'b0, 2, 8'd10);
    endtask

    task automatic t_stack();
        run("R5 stack ok", 2'd2, 16'h0023, 2'd3, 32'h0000FFFF,
            hiw(8'h00, 1'b1, 4'hF, 1'b1, 2'd3, 1'b1, 4'h2, 8'h00), 1'b0, 1, 8'd0);
        chk("R9 limit page gran", ld_limit, 32'hFFFFFFFF);
        run("R5 read-only data", 2'd2, 16'h0023, 2'd3, 32'h0,
            hiw(8'h0, 1'b0, 4'h0, 1'b1, 2'd3, 1'b1, 4'h0, 8'h0), 1'b0, 2, 8'd10);
        run("R5 dpl ne cpl", 2'd2, 16'h0023, 2'd0, 32'h0,
            hiw(8'h0, 1'b0, 4'h0, 1'b1, 2'd3, 1'b1, 4'h2, 8'h0), 1'b0, 2, 8'd10);
    endtask

    task automatic t_data();
        run("R6 exec-only code", 2'd0, 16'h0030, 2'd0, 32'h0,
            hiw(8'h0, 1'b0, 4'h0, 1'b1, 2'd0, 1'b1, 4'h8, 8'h0), 1'b0, 2, 8'd10);
        run("R6 data dpl lt cpl", 2'd0, 16'h0030, 2'd3, 32'h0,
            hiw(8'h0, 1'b0, 4'h0, 1'b1, 2'd0, 1'b1, 4'h2, 8'h0), 1'b0, 2, 8'd10);
        run("R6 data dpl lt rpl", 2'd0, 16'h0032, 2'd0, 32'h0,
            hiw(8'h0, 1'b0, 4'h0, 1'b1, 2'd1, 1'b1, 4'h2, 8'h0), 1'b0, 2, 8'd10);
        run("R6 conforming low dpl ok", 2'd0, 16'h0033, 2'd3, 32'h00000001,
            hiw(8'h0, 1'b1, 4'h0, 1'b1, 2'd0, 1'b1, 4'hE, 8'h0), 1'b0, 1, 8'd0);
        chk("R9 small page limit", ld_limit, 32'h00001FFF);
    endtask

    task automatic t_present();
        run("R7 not present", 2'd0, 16'h0041, 2'd0, 32'h0,
            hiw(8'h0, 1'b0, 4'h0, 1'b0, 2'd3, 1'b1, 4'h2, 8'h0), 1'b0, 2, 8'd11);
        run("R7 absent and priv bad", 2'd0, 16'h0041, 2'd3, 32'h0,
            hiw(8'h0, 1'b0, 4'h0, 1'b0, 2'd0, 1'b1, 4'h2, 8'h0), 1'b0, 2, 8'd10);
        run("R7 absent stack", 2'd2, 16'h0040, 2'd0, 32'h0,
            hiw(8'h0, 1'b0, 4'h0, 1'b0, 2'd0, 1'b1, 4'h2, 8'h0), 1'b0, 2, 8'd11);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_null();
        t_fetch_sys();
        t_code();
        t_stack();
        t_data();
        t_present();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule